// File: doc/BRIEF.md
# Slotted Instruction Word Sequencer

This block is the front end of a small stack processor. It reads one 32-bit instruction word at a time from an instruction memory and hands the five-bit opcodes packed inside it, one by one, to an execute stage over a valid/ready port. Six opcode slots share each word. The two remaining bits say what happens once the slots are used up: a literal is pushed on the data stack, control jumps, the same slots run again as a micro-loop, or a subroutine is called.

The sequencer holds the program counter, an eight-entry return stack for calls and a loop counter. Software-visible loop counts arrive through a dedicated load port ahead of a loop word. Opcode execution and data memory live elsewhere. The literal value leaves on its own output for one cycle so the stack unit can push it. The instruction memory is read combinationally: the address and read strobe go out and the data comes back in the same cycle.

Top module: `slotword_sequencer`

## Requirements
- R1: While reset is low the block drives address 0 with the read strobe high and asserts neither issue-valid nor literal-valid, so the first word fetched after reset is the one at address 0.
- R2: A fetched word carries its mode in bits [31:30] and six opcode slots below it; slot 0 is bits [29:25], slot k is bits [29-5k:25-5k], and non-skipped slots reach the execute port in ascending slot order.
- R3: Opcode 0 is a no-op: it costs one cycle and is never presented on the execute port; opcode 31 is never presented either.
- R4: When issue-valid is high and ready is low, the next cycle keeps issue-valid high with the same opcode; nothing advances until ready is high.
- R5: Mode 00 (literal): after the slots, the following memory word is presented on the literal output with literal-valid high for exactly one cycle, and fetching resumes at the address after it.
- R6: Mode 01 (jump): after the slots, the low 10 bits of the following memory word become the address of the next fetched word.
- R7: Mode 11 (call): after the slots, the address just past the operand word is pushed onto the return stack and the low 10 bits of the operand word become the next fetch address.
- R8: Opcode 31 is return: with a non-empty return stack it pops the top entry, continues fetching there and drops the rest of the word's slots and its mode; with an empty stack it acts as a no-op.
- R9: The return stack holds 8 entries; a call made while it is full discards the oldest entry, so the ninth return of a nine-deep nesting finds the stack empty.
- R10: Mode 10 (micro-loop) has no operand word: after the slots, a nonzero counter is decremented and the same slots are issued again with no memory read; a zero counter lets the sequencer fetch the next word, so a counter of N gives N+1 passes.
- R11: A load strobe on the counter port writes the counter value on the next clock edge, taking priority over any decrement in that cycle; the counter is not reloaded by the loop itself.
- R12: Memory is read only for a word fetch and for the operand of a literal, jump or call word; no read occurs while slots issue or while a micro-loop repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_addr | output | 10 | Instruction memory word address (program counter) |
| imem_rdata | input | 32 | Instruction memory read data, same cycle |
| lc_load | input | 1 | Load strobe for the micro-loop counter |
| lc_value | input | 8 | Value written into the micro-loop counter |
| iss_valid | output | 1 | An opcode is offered to the execute stage |
| iss_op | output | 5 | Opcode offered to the execute stage |
| iss_ready | input | 1 | Execute stage accepts the offered opcode |
| lit_valid | output | 1 | Literal push request, one cycle |
| lit_data | output | 32 | Literal value to push |

## Verification
On every cycle the assertions check the handshake hold under back-pressure, that neither control opcode nor a no-op ever reaches the execute port, that a literal lasts one cycle and coincides with an operand read, that no memory read overlaps slot issue, the return stack occupancy bound and the counter load priority. Whether the right opcodes arrive in the right order across jumps, calls, returns and loop repeats, whether literals carry the right values, and how many memory reads a program costs can only be shown by the bench, which runs whole programs against its own interpreter. The nine-deep call chain and the counted micro-loop are directed scenarios with fixed expected totals.

// File: rtl/slotseq_pkg.sv
// Shared types for the slotted instruction word sequencer.
// Assumes the word mode field is always two bits wide.
package slotseq_pkg;

    // Meaning of the two mode bits at the top of each instruction word.
    typedef enum logic [1:0] {
        MODE_LIT  = 2'b00,
        MODE_JUMP = 2'b01,
        MODE_LOOP = 2'b10,
        MODE_CALL = 2'b11
    } word_mode_e;

    // Sequencer phase: fetch a word, walk its slots, then act on its mode.
    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_SLOT  = 2'b01,
        ST_TAIL  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/slotseq_slot_pick.sv
// Selects one opcode slot out of the packed slot field of a word.
// Assumes slot 0 sits in the most significant bits of the field and that
// idx never exceeds NSLOT-1; an out-of-range index yields opcode 0.
module slotseq_slot_pick #(
    parameter int OP_W  = 5,
    parameter int NSLOT = 6,
    parameter int IDX_W = 3
) (
    input  logic [NSLOT*OP_W-1:0] field,
    input  logic [IDX_W-1:0]      idx,
    output logic [OP_W-1:0]       op
);

    logic [OP_W-1:0] slot_arr [NSLOT];

    // Unpack the field into slots, slot 0 from the top bits.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_arr[g] = field[NSLOT*OP_W-1-g*OP_W -: OP_W];
    end

    // Index the slot array with the current slot number.
    always_comb begin
        op = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (idx == IDX_W'(i)) op = slot_arr[i];
        end
    end

endmodule

// File: rtl/slotseq_ret_stack.sv
// Circular return-address stack. A push on a full stack overwrites the
// oldest entry and leaves the count saturated. A pop on an empty stack is
// ignored. Assumes DEPTH is a power of two and push and pop are never
// requested together (push wins if they are).
module slotseq_ret_stack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 10,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic [CW-1:0]     count
);

    logic [ADDR_W-1:0] entry_q [DEPTH];
    logic [PW-1:0]     ptr_q;
    logic [CW-1:0]     count_q;

    // Write pointer, occupancy and entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (push) begin
            entry_q[ptr_q] <= push_addr;
            ptr_q          <= ptr_q + 1'b1;
            if (count_q != CW'(DEPTH)) count_q <= count_q + 1'b1;
        end else if (pop && count_q != '0) begin
            ptr_q   <= ptr_q - 1'b1;
            count_q <= count_q - 1'b1;
        end
    end

    // Most recently pushed entry sits just below the write pointer.
    assign top_addr = entry_q[ptr_q - 1'b1];
    assign count    = count_q;

endmodule

// File: rtl/slotseq_loop_ctr.sv
// Micro-loop repeat counter. A load takes priority over a decrement.
// Assumes the caller only decrements a nonzero count.
module slotseq_loop_ctr #(
    parameter int LC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LC_W-1:0] value,
    input  logic            dec,
    output logic [LC_W-1:0] count
);

    // Hold, load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (load) count <= value;
        else if (dec)  count <= count - 1'b1;
    end

endmodule

// File: rtl/slotword_sequencer.sv
// Fetch and sequencing unit for a stack processor with six 5-bit opcode
// slots per 32-bit word and a 2-bit word mode. Per word: one fetch cycle,
// one cycle per slot (longer while the execute port stalls), then one tail
// cycle that acts on the mode. Assumes the instruction memory answers in the
// same cycle and the literal consumer always accepts.
module slotword_sequencer #(
    parameter int WORD_W   = 32,
    parameter int OP_W     = 5,
    parameter int ADDR_W   = 10,
    parameter int LC_W     = 8,
    parameter int RS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              imem_rd,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    input  logic              lc_load,
    input  logic [LC_W-1:0]   lc_value,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    input  logic              iss_ready,
    output logic              lit_valid,
    output logic [WORD_W-1:0] lit_data
);
    import slotseq_pkg::*;

    localparam int MODE_W  = 2;
    localparam int NSLOT   = (WORD_W - MODE_W) / OP_W;
    localparam int FIELD_W = NSLOT * OP_W;
    localparam int IDX_W   = $clog2(NSLOT);
    localparam int RS_CW   = $clog2(RS_DEPTH + 1);
    localparam logic [OP_W-1:0] OP_NOP = '0;
    localparam logic [OP_W-1:0] OP_RET = '1;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    logic [OP_W-1:0]   slot_op;
    word_mode_e        mode;
    logic              in_slot, in_tail, last_slot;
    logic              is_nop, is_ret, rs_empty;
    logic              do_ret, pass_slot, slot_done;
    logic              rs_push, lc_dec, lc_nz;
    logic [ADDR_W-1:0] pc_inc, operand_addr, rs_top;
    logic [LC_W-1:0]   lc_count;
    logic [RS_CW-1:0]  rs_count;

    // Pick the opcode of the current slot out of the held word.
    slotseq_slot_pick #(
        .OP_W (OP_W),
        .NSLOT(NSLOT),
        .IDX_W(IDX_W)
    ) u_pick (
        .field(word_q[WORD_W-MODE_W-1 -: FIELD_W]),
        .idx  (idx_q),
        .op   (slot_op)
    );

    // Return addresses for calls.
    slotseq_ret_stack #(
        .DEPTH (RS_DEPTH),
        .ADDR_W(ADDR_W)
    ) u_rstack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rs_push),
        .pop      (do_ret),
        .push_addr(pc_inc),
        .top_addr (rs_top),
        .count    (rs_count)
    );

    // Repeat counter for micro-loop words.
    slotseq_loop_ctr #(
        .LC_W(LC_W)
    ) u_lctr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (lc_load),
        .value(lc_value),
        .dec  (lc_dec),
        .count(lc_count)
    );

    // Decode the current phase, slot and mode into control strobes.
    always_comb begin
        mode         = word_mode_e'(word_q[WORD_W-1 -: MODE_W]);
        in_slot      = (state_q == ST_SLOT);
        in_tail      = (state_q == ST_TAIL);
        last_slot    = (idx_q == IDX_W'(NSLOT - 1));
        is_nop       = (slot_op == OP_NOP);
        is_ret       = (slot_op == OP_RET);
        rs_empty     = (rs_count == '0);
        lc_nz        = (lc_count != '0);
        pc_inc       = pc_q + 1'b1;
        operand_addr = imem_rdata[ADDR_W-1:0];

        do_ret    = in_slot && is_ret && !rs_empty;
        pass_slot = in_slot && (is_nop || (is_ret && rs_empty));
        iss_valid = in_slot && !is_nop && !is_ret;
        slot_done = pass_slot || (iss_valid && iss_ready);

        imem_rd   = (state_q == ST_FETCH) || (in_tail && mode != MODE_LOOP);
        lit_valid = in_tail && (mode == MODE_LIT);
        rs_push   = in_tail && (mode == MODE_CALL);
        lc_dec    = in_tail && (mode == MODE_LOOP) && lc_nz;
    end

    assign imem_addr = pc_q;
    assign iss_op    = slot_op;
    assign lit_data  = imem_rdata;

    // Phase sequencing, program counter, held word and slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            word_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    word_q  <= imem_rdata;
                    pc_q    <= pc_inc;
                    idx_q   <= '0;
                    state_q <= ST_SLOT;
                end
                ST_SLOT: begin
                    if (do_ret) begin
                        pc_q    <= rs_top;
                        state_q <= ST_FETCH;
                    end else if (slot_done) begin
                        if (last_slot) state_q <= ST_TAIL;
                        else           idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    unique case (mode)
                        MODE_LIT: begin
                            pc_q    <= pc_inc;
                            state_q <= ST_FETCH;
                        end
                        MODE_JUMP, MODE_CALL: begin
                            pc_q    <= operand_addr;
                            state_q <= ST_FETCH;
                        end
                        MODE_LOOP: begin
                            idx_q   <= '0;
                            state_q <= lc_nz ? ST_SLOT : ST_FETCH;
                        end
                    endcase
                end
                default: state_q <= ST_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/slotseq_checker.sv
// Property checker for the slotted instruction word sequencer, bound to
// every instance of the top module. Observes ports plus the loop counter
// and return stack occupancy.
module slotseq_checker #(
    parameter int OP_W     = 5,
    parameter int LC_W     = 8,
    parameter int RS_DEPTH = 8,
    localparam int RS_CW   = $clog2(RS_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [OP_W-1:0]  iss_op,
    input logic             lit_valid,
    input logic             imem_rd,
    input logic             lc_load,
    input logic [LC_W-1:0]  lc_value,
    input logic [LC_W-1:0]  lc_count,
    input logic [RS_CW-1:0] rs_count
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready |=> iss_valid && $stable(iss_op)); // R4

    AST_NO_NOP_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_op != '0); // R3

    AST_NO_RET_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_op != '1); // R8

    AST_LIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lit_valid |=> !lit_valid); // R5

    AST_LIT_READS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        lit_valid |-> imem_rd && !iss_valid); // R12

    AST_ISSUE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !imem_rd); // R12

    AST_RS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rs_count <= RS_CW'(RS_DEPTH)); // R9

    AST_LC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lc_load) |-> lc_count == $past(lc_value)); // R11

endmodule

bind slotword_sequencer slotseq_checker #(
    .OP_W    (OP_W),
    .LC_W    (LC_W),
    .RS_DEPTH(RS_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_ready(iss_ready),
    .iss_op   (iss_op),
    .lit_valid(lit_valid),
    .imem_rd  (imem_rd),
    .lc_load  (lc_load),
    .lc_value (lc_value),
    .lc_count (lc_count),
    .rs_count (rs_count)
);

// File: tb/slotword_sequencer_bench.sv
// Bench: builds programs in a behavioural instruction memory, runs them with
// random or directed back-pressure and compares the issued opcode stream,
// literal stream and memory read count with a bench-side interpreter.
module slotword_sequencer_bench;

    localparam int HALT = 1000;
    localparam int SUB  = 600;
    localparam int CHN  = 700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_rd;
    logic [9:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic        lc_load = 1'b0;
    logic [7:0]  lc_value = '0;
    logic        iss_valid;
    logic [4:0]  iss_op;
    logic        iss_ready = 1'b1;
    logic        lit_valid;
    logic [31:0] lit_data;

    logic [31:0] mem [0:1023];
    assign imem_rdata = mem[imem_addr];

    slotword_sequencer u_slotword_sequencer (
        .clk(clk), .rst_n(rst_n), .imem_rd(imem_rd), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .lc_load(lc_load), .lc_value(lc_value),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_ready(iss_ready),
        .lit_valid(lit_valid), .lit_data(lit_data)
    );

    always #4 clk = ~clk; // 125 MHz

    int n_checks = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
    int exp_ops [0:4095];  int exp_n;
    int got_ops [0:4095];  int got_n;
    logic [31:0] exp_lits [0:1023]; int exp_nl;
    logic [31:0] got_lits [0:1023]; int got_nl;
    int exp_reads, got_reads, stall_err, bad_ctrl;
    logic prev_stall; logic [4:0] prev_op;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Back-pressure driver, changes ready just after each rising edge.
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: iss_ready <= 1'b1;
            1: iss_ready <= ($urandom % 10) < 6;
            default: iss_ready <= ($urandom % 8) == 0;
        endcase
    end

    // Port monitor, samples at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(iss_valid && iss_op == prev_op)) stall_err++;
            prev_stall = iss_valid && !iss_ready;
            prev_op    = iss_op;
            if (iss_valid && (iss_op == 5'd0 || iss_op == 5'd31)) bad_ctrl++;
            if (iss_valid && iss_ready) begin got_ops[got_n] = int'(iss_op); got_n++; end
            if (lit_valid) begin got_lits[got_nl] = lit_data; got_nl++; end
            if (imem_rd && imem_addr != 10'(HALT) && imem_addr != 10'(HALT + 1)) got_reads++;
        end
    end

    function automatic logic [31:0] mkw(input logic [1:0] m, input logic [4:0] a, b, c,
                                        input logic [4:0] d, e, f);
        return {m, a, b, c, d, e, f};
    endfunction

    function automatic logic [4:0] rop(input bit allow_ret);
        int r;
        r = $urandom % 100;
        if (r < 25) return 5'd0;
        if (allow_ret && r < 30) return 5'd31;
        return 5'(1 + $urandom % 30);
    endfunction

    // Interpreter built from the requirements: expected ops, literals, reads.
    task automatic model(input int lcv);
        int pc, lc, rsp, rcnt, guard;
        int rs [8];
        logic [31:0] w;
        bit again, ret;
        pc = 0; lc = lcv; rsp = 0; rcnt = 0; guard = 0;
        exp_n = 0; exp_nl = 0; exp_reads = 0;
        for (int i = 0; i < 8; i++) rs[i] = 0;
        while (pc != HALT && guard < 1000) begin
            guard++;
            w = mem[pc]; exp_reads++; pc = (pc + 1) % 1024;
            again = 1'b1;
            while (again) begin
                again = 1'b0; ret = 1'b0;
                for (int i = 0; i < 6; i++) begin
                    int op;
                    op = int'(w[29 - 5*i -: 5]);
                    if (op == 31) begin
                        if (rcnt > 0) begin
                            rsp = (rsp + 7) % 8; rcnt--; pc = rs[rsp]; ret = 1'b1;
                            break;
                        end
                    end else if (op != 0) begin
                        exp_ops[exp_n] = op; exp_n++;
                    end
                end
                if (!ret) begin
                    case (w[31:30])
                        2'b00: begin exp_lits[exp_nl] = mem[pc]; exp_nl++; exp_reads++; pc = (pc + 1) % 1024; end
                        2'b01: begin exp_reads++; pc = int'(mem[pc][9:0]); end
                        2'b11: begin
                            exp_reads++; rs[rsp] = (pc + 1) % 1024; rsp = (rsp + 1) % 8;
                            if (rcnt < 8) rcnt++;
                            pc = int'(mem[pc][9:0]);
                        end
                        default: if (lc != 0) begin lc--; again = 1'b1; end
                    endcase
                end
            end
        end
    endtask

    task automatic put_halt(input int a);
        mem[a]        = mkw(2'b01, 0, 0, 0, 0, 0, 0);
        mem[a + 1]    = 32'(HALT);
        mem[HALT]     = mkw(2'b01, 0, 0, 0, 0, 0, 0);
        mem[HALT + 1] = 32'(HALT);
    endtask

    // Random main program with forward jumps, literals, loops and calls.
    task automatic gen_random();
        int a;
        for (int k = 0; k < 1024; k++) mem[k] = $urandom;
        a = 0;
        for (int w = 0; w < 12; w++) begin
            logic [1:0] m;
            int k2;
            m = 2'($urandom % 4);
            mem[a] = mkw(m, rop(1), rop(1), rop(1), rop(1), rop(1), rop(1));
            a++;
            case (m)
                2'b00: begin mem[a] = $urandom; a++; end
                2'b01: begin k2 = $urandom % 3; mem[a] = 32'(a + 1 + k2); a = a + 1 + k2; end
                2'b11: begin mem[a] = 32'(SUB + 16 * ($urandom % 4)); a++; end
                default: ;
            endcase
        end
        put_halt(a);
        for (int s = 0; s < 4; s++) begin
            int b, nb, j;
            logic [1:0] m0;
            logic [4:0] sl [6];
            b  = SUB + 16 * s;
            m0 = ($urandom % 2) ? 2'b00 : 2'b10;
            mem[b] = mkw(m0, rop(0), rop(0), rop(0), rop(0), rop(0), rop(0));
            nb = (m0 == 2'b00) ? b + 2 : b + 1;
            j  = $urandom % 6;
            for (int i = 0; i < 6; i++) sl[i] = (i == j) ? 5'd31 : rop(0);
            mem[nb] = mkw(2'($urandom % 4), sl[0], sl[1], sl[2], sl[3], sl[4], sl[5]);
        end
    endtask

    task automatic gen_loop();
        for (int k = 0; k < 1024; k++) mem[k] = $urandom;
        mem[0] = mkw(2'b10, 5'd1, 5'd2, 5'd0, 5'd3, 5'd0, 5'd4);
        mem[1] = mkw(2'b10, 5'd5, 5'd0, 5'd0, 5'd0, 5'd0, 5'd6);
        put_halt(2);
    endtask

    // Nine nested calls through an eight-entry stack.
    task automatic gen_chain();
        for (int k = 0; k < 1024; k++) mem[k] = $urandom;
        mem[0] = mkw(2'b11, 0, 0, 0, 0, 0, 0);
        mem[1] = 32'(CHN);
        for (int k = 0; k < 8; k++) begin
            int b;
            b = CHN + 4 * k;
            mem[b]     = mkw(2'b11, 5'(k + 1), 0, 0, 0, 0, 0);
            mem[b + 1] = 32'(b + 4);
            mem[b + 2] = mkw(2'b01, 5'd31, 5'd9, 0, 0, 0, 0);
            mem[b + 3] = 32'(HALT);
        end
        mem[CHN + 32] = mkw(2'b00, 5'd31, 0, 0, 0, 0, 0);
        mem[HALT]     = mkw(2'b01, 0, 0, 0, 0, 0, 0);
        mem[HALT + 1] = 32'(HALT);
    endtask

    task automatic run(input int lcv, input int rmode);
        @(posedge clk); #1;
        rst_n = 1'b0; lc_load = 1'b0; rdy_mode = rmode;
        repeat (2) @(posedge clk);
        #1;
        got_n = 0; got_nl = 0; got_reads = 0; stall_err = 0; bad_ctrl = 0;
        prev_stall = 1'b0; prev_op = '0;
        model(lcv);
        @(negedge clk);
        check(imem_addr == 10'd0 && imem_rd, "R1", "reset fetch address/strobe",
              imem_addr, 0);
        check(!iss_valid && !lit_valid, "R1", "reset quiet outputs",
              {iss_valid, lit_valid}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1; lc_load = 1'b1; lc_value = 8'(lcv);
        @(posedge clk); #1;
        lc_load = 1'b0;
        repeat (4000) @(posedge clk);
        #1;
        begin
            int bad;
            bad = -1;
            check(got_n == exp_n, "R2", "issued opcode count", got_n, exp_n);
            for (int i = 0; i < exp_n && i < got_n; i++)
                if (bad < 0 && got_ops[i] != exp_ops[i]) bad = i;
            check(bad < 0, "R2 R6 R7 R8", "opcode stream",
                  bad < 0 ? 0 : got_ops[bad], bad < 0 ? 0 : exp_ops[bad]);
            check(bad_ctrl == 0, "R3", "no-op or return issued", bad_ctrl, 0);
            check(stall_err == 0, "R4", "stall hold violations", stall_err, 0);
            check(got_nl == exp_nl, "R5", "literal count", got_nl, exp_nl);
            bad = -1;
            for (int i = 0; i < exp_nl && i < got_nl; i++)
                if (bad < 0 && got_lits[i] != exp_lits[i]) bad = i;
            check(bad < 0, "R5", "literal values",
                  bad < 0 ? 0 : got_lits[bad], bad < 0 ? 0 : exp_lits[bad]);
            check(got_reads == exp_reads, "R12", "memory reads", got_reads, exp_reads);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 5; s++) begin
            gen_random();
            run($urandom % 4, 1);
        end
        // Counted micro-loop: load 3 -> four passes, then a zero-count loop once.
        gen_loop();
        run(3, 0);
        check(got_n == 18, "R10 R11", "loop issue total", got_n, 18);
        check(got_reads == 4, "R10 R12", "loop reads", got_reads, 4);
        // Nine-deep call chain under heavy back-pressure.
        gen_chain();
        run(0, 2);
        check(got_n == 9, "R9", "chain issue total", got_n, 9);
        check(got_n > 0 && got_ops[got_n - 1] == 9, "R9 R8", "empty-stack return falls through",
              got_n > 0 ? got_ops[got_n - 1] : -1, 9);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule